// File: doc/BRIEF.md
# Latency-Scheduled Packet Stream Transmitter

This block sends packet-framed beats to a downstream sink whose ready signal runs ahead of the data by a fixed number of cycles. Upstream logic writes beats into a small internal buffer through a push strobe and watches a full flag. Each beat carries its payload, start and end-of-packet markers, a count of unused symbol lanes, a channel number and an error code.

Downstream, the sink raises ready to grant a later cycle. The block delays ready through a shift register as deep as the configured latency, which may be 1 or 2. A cycle whose delayed ready is high is a granted cycle. The block drives valid only in a granted cycle, and only when the buffer holds a beat. In every other cycle valid and all beat fields sit at zero. Nothing held back from a granted cycle is ever sent in a later cycle that was not granted.

The packet marker and lane-count outputs are always present. The block offers no mode that removes them.

Top module: `latStreamTx`

## Requirements
- R1: After reset, outValid and inFull are low and outData, outSop, outEop, outEmpty, outChan and outErr are all zero.
- R2: outValid is high only in a cycle where outReady was high exactly LATENCY clock cycles earlier. LATENCY is 1 or 2, and the default is 2.
- R3: In every granted cycle where the buffer holds at least one beat, outValid is high and the oldest beat leaves.
- R4: In a granted cycle with an empty buffer, outValid stays low. A beat pushed afterwards waits for the next granted cycle.
- R5: Beats leave in the order they were accepted, with outData, outSop, outEop, outChan and outErr equal to the pushed values. Packets therefore arrive whole, each opening with outSop and closing with outEop.
- R6: When outValid and outEop are high, outEmpty equals the lane count pushed with that beat. On every other cycle outEmpty is zero, even if a nonzero count was pushed with a beat that had no end marker.
- R7: While outValid is low, outData, outSop, outEop, outEmpty, outChan and outErr are all zero.
- R8: inFull is high exactly when the buffer holds DEPTH beats (default LATENCY+2). A push while inFull is high is dropped: that beat never appears, and the beats already stored are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inPush | input | 1 | Write one beat into the buffer |
| inData | input | SYMBOLS*SYM_W | Beat payload |
| inSop | input | 1 | Beat opens a packet |
| inEop | input | 1 | Beat closes a packet |
| inEmpty | input | EMPTY_W | Unused symbol lanes in a closing beat |
| inChan | input | CHAN_W | Channel number |
| inErr | input | ERR_W | Error code |
| inFull | output | 1 | Buffer holds DEPTH beats; pushes are dropped |
| outReady | input | 1 | Sink grant for the cycle LATENCY cycles later |
| outValid | output | 1 | Beat presented in a granted cycle |
| outData | output | SYMBOLS*SYM_W | Payload, zero when idle |
| outSop | output | 1 | Start-of-packet marker |
| outEop | output | 1 | End-of-packet marker |
| outEmpty | output | EMPTY_W | Unused lanes, nonzero only on closing beats |
| outChan | output | CHAN_W | Channel number, zero when idle |
| outErr | output | ERR_W | Error code, zero when idle |

## Verification
Two situations are hard to reach from the ports: a push arriving while the buffer is full, and a grant arriving while the buffer is empty. For the first, one phase of the stimulus holds ready low while pushing every cycle, so that the buffer fills and extra pushes are dropped. For the second, another phase holds ready high while pushing only rarely, so that granted cycles find the buffer empty. The other phases sweep ready patterns that are steady, periodic and random. Packet lengths are random, and lane counts are pushed on every beat so that the masking on non-closing beats is exercised. A cycle-accurate queue model in the bench predicts each output.

// File: rtl/latStreamPkg.sv
package latStreamPkg;
  // strobes from the control path into the buffer datapath
  typedef struct packed {
    logic push;
    logic pop;
  } strobe_t;
endpackage

// File: rtl/latStreamCtrl.sv
module latStreamCtrl
  import latStreamPkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inPush,
  input  logic    outReady,
  input  logic    bufFull,
  input  logic    bufEmpty,
  output strobe_t strobe,
  output logic    validOut
);
  logic [LATENCY-1:0] rdyPipe;

  generate
    if (LATENCY == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (!rstN) rdyPipe <= '0;
        else       rdyPipe <= outReady;
      end
    end else begin : gMulti
      always_ff @(posedge clk) begin
        if (!rstN) rdyPipe <= '0;
        else       rdyPipe <= {rdyPipe[LATENCY-2:0], outReady};
      end
    end
  endgenerate

  // the oldest stage marks the current cycle as granted
  logic grantNow;
  assign grantNow = rdyPipe[LATENCY-1];

  always_comb begin
    strobe.push = inPush & ~bufFull;
    strobe.pop  = grantNow & ~bufEmpty;
  end

  assign validOut = strobe.pop;
endmodule

// File: rtl/latStreamBuf.sv
module latStreamBuf
  import latStreamPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EMPTY_W = 2,
  parameter int CHAN_W  = 3,
  parameter int ERR_W   = 2,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [DATA_W-1:0]  inData,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [EMPTY_W-1:0] inEmpty,
  input  logic [CHAN_W-1:0]  inChan,
  input  logic [ERR_W-1:0]   inErr,
  output logic               bufFull,
  output logic               bufEmpty,
  output logic [DATA_W-1:0]  outData,
  output logic               outSop,
  output logic               outEop,
  output logic [EMPTY_W-1:0] outEmpty,
  output logic [CHAN_W-1:0]  outChan,
  output logic [ERR_W-1:0]   outErr
);
  localparam int BEAT_W = DATA_W + 2 + EMPTY_W + CHAN_W + ERR_W;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [BEAT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  assign bufFull  = (count == CNT_W'(DEPTH));
  assign bufEmpty = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strobe.push) begin
        mem[wrPtr] <= {inData, inSop, inEop, inEmpty, inChan, inErr};
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (strobe.pop)
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  logic [DATA_W-1:0]  headData;
  logic               headSop, headEop;
  logic [EMPTY_W-1:0] headEmpty;
  logic [CHAN_W-1:0]  headChan;
  logic [ERR_W-1:0]   headErr;

  assign {headData, headSop, headEop, headEmpty, headChan, headErr} = mem[rdPtr];

  // every field is forced quiet outside a presented beat
  always_comb begin
    outData  = strobe.pop ? headData : '0;
    outSop   = strobe.pop & headSop;
    outEop   = strobe.pop & headEop;
    outEmpty = (strobe.pop & headEop) ? headEmpty : '0;
    outChan  = strobe.pop ? headChan : '0;
    outErr   = strobe.pop ? headErr : '0;
  end
endmodule

// File: rtl/latStreamTx.sv
module latStreamTx
  import latStreamPkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int SYMBOLS = 4,
  parameter int CHAN_W  = 3,
  parameter int ERR_W   = 2,
  parameter int LATENCY = 2,
  parameter int DEPTH   = LATENCY + 2,
  localparam int DATA_W  = SYM_W * SYMBOLS,
  localparam int EMPTY_W = (SYMBOLS > 1) ? $clog2(SYMBOLS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inPush,
  input  logic [DATA_W-1:0]  inData,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [EMPTY_W-1:0] inEmpty,
  input  logic [CHAN_W-1:0]  inChan,
  input  logic [ERR_W-1:0]   inErr,
  output logic               inFull,
  input  logic               outReady,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  output logic               outSop,
  output logic               outEop,
  output logic [EMPTY_W-1:0] outEmpty,
  output logic [CHAN_W-1:0]  outChan,
  output logic [ERR_W-1:0]   outErr
);
  generate
    if (LATENCY < 1 || LATENCY > 2) begin : gBadLatency
      $error("latStreamTx: LATENCY must be 1 or 2");
    end
    if (DEPTH < LATENCY + 1) begin : gBadDepth
      $error("latStreamTx: DEPTH must be at least LATENCY+1");
    end
  endgenerate

  strobe_t strobe;
  logic    bufFull, bufEmpty;

  latStreamCtrl #(.LATENCY(LATENCY)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inPush   (inPush),
    .outReady (outReady),
    .bufFull  (bufFull),
    .bufEmpty (bufEmpty),
    .strobe   (strobe),
    .validOut (outValid)
  );

  latStreamBuf #(
    .DATA_W (DATA_W),
    .EMPTY_W(EMPTY_W),
    .CHAN_W (CHAN_W),
    .ERR_W  (ERR_W),
    .DEPTH  (DEPTH)
  ) buffer (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inData   (inData),
    .inSop    (inSop),
    .inEop    (inEop),
    .inEmpty  (inEmpty),
    .inChan   (inChan),
    .inErr    (inErr),
    .bufFull  (bufFull),
    .bufEmpty (bufEmpty),
    .outData  (outData),
    .outSop   (outSop),
    .outEop   (outEop),
    .outEmpty (outEmpty),
    .outChan  (outChan),
    .outErr   (outErr)
  );

  assign inFull = bufFull;
endmodule

// File: rtl/latStreamTxChecker.sv
module latStreamTxChecker #(
  parameter int DATA_W  = 32,
  parameter int EMPTY_W = 2,
  parameter int CHAN_W  = 3,
  parameter int ERR_W   = 2,
  parameter int LATENCY = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               inPush,
  input logic               inFull,
  input logic               outReady,
  input logic               outValid,
  input logic [DATA_W-1:0]  outData,
  input logic               outSop,
  input logic               outEop,
  input logic [EMPTY_W-1:0] outEmpty,
  input logic [CHAN_W-1:0]  outChan,
  input logic [ERR_W-1:0]   outErr
);
  // clock edges seen since reset, saturating
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  a_r2_no_early_valid: assert property (@(posedge clk) disable iff (!rstN)
    (32'(sinceRst) < LATENCY) |-> !outValid);

  a_r2_valid_in_granted_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && 32'(sinceRst) >= LATENCY) |-> $past(outReady, LATENCY));

  a_r7_idle_fields_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outData == '0 && !outSop && !outEop && outEmpty == '0
                   && outChan == '0 && outErr == '0));

  a_r6_empty_only_closing: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outEop) |-> (outEmpty == '0));

  a_r8_full_push_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (inFull && inPush && !outValid) |=> inFull);
endmodule

bind latStreamTx latStreamTxChecker #(
  .DATA_W (DATA_W),
  .EMPTY_W(EMPTY_W),
  .CHAN_W (CHAN_W),
  .ERR_W  (ERR_W),
  .LATENCY(LATENCY)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .inPush   (inPush),
  .inFull   (inFull),
  .outReady (outReady),
  .outValid (outValid),
  .outData  (outData),
  .outSop   (outSop),
  .outEop   (outEop),
  .outEmpty (outEmpty),
  .outChan  (outChan),
  .outErr   (outErr)
);

// File: tb/latStreamTx_test.sv
module latStreamTx_test;
  localparam int LAT     = 2;
  localparam int DEPTH   = LAT + 2;
  localparam int SYM_W   = 8;
  localparam int SYMBOLS = 4;
  localparam int DATA_W  = SYM_W * SYMBOLS;
  localparam int EMPTY_W = 2;
  localparam int CHAN_W  = 3;
  localparam int ERR_W   = 2;
  localparam int QN      = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inPush = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic inSop = 1'b0, inEop = 1'b0;
  logic [EMPTY_W-1:0] inEmpty = '0;
  logic [CHAN_W-1:0] inChan = '0;
  logic [ERR_W-1:0] inErr = '0;
  logic inFull;
  logic outReady = 1'b0;
  logic outValid;
  logic [DATA_W-1:0] outData;
  logic outSop, outEop;
  logic [EMPTY_W-1:0] outEmpty;
  logic [CHAN_W-1:0] outChan;
  logic [ERR_W-1:0] outErr;

  always #5 clk = ~clk;

  latStreamTx #(
    .SYM_W(SYM_W), .SYMBOLS(SYMBOLS), .CHAN_W(CHAN_W), .ERR_W(ERR_W),
    .LATENCY(LAT), .DEPTH(DEPTH)
  ) uut (.*);

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  // queue model of accepted beats
  logic [DATA_W-1:0]  qData [QN];
  logic               qSop  [QN];
  logic               qEop  [QN];
  logic [EMPTY_W-1:0] qEmp  [QN];
  logic [CHAN_W-1:0]  qChan [QN];
  logic [ERR_W-1:0]   qErr  [QN];
  int qHead = 0, qTail = 0, qCount = 0;
  bit hist [LAT];
  int pktLeft = 0;
  bit outInPkt = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic stepCycle(input bit rdy, input bit pushReq);
    bit expGrant, expValid, expFull, accept, sop, eop;
    int len;
    logic [DATA_W-1:0] d;
    logic [EMPTY_W-1:0] em;
    logic [CHAN_W-1:0] ch;
    logic [ERR_W-1:0] er;
    expGrant = hist[LAT-1];
    expValid = expGrant && (qCount > 0);
    expFull  = (qCount == DEPTH);
    if (!expValid && !expGrant)
      check(outValid == 1'b0, "R2", "valid outside granted cycle", 64'(outValid), 0);
    else if (!expValid)
      check(outValid == 1'b0, "R4", "valid with empty buffer", 64'(outValid), 0);
    else
      check(outValid == 1'b1, "R3", "granted beat not sent", 64'(outValid), 1);
    check(inFull == expFull, "R8", "full flag", 64'(inFull), 64'(expFull));
    if (expValid) begin
      check(outData == qData[qHead], "R5", "data order", 64'(outData), 64'(qData[qHead]));
      check({outSop, outEop, outChan, outErr} == {qSop[qHead], qEop[qHead], qChan[qHead], qErr[qHead]},
            "R5", "markers/channel/error", 64'({outSop, outEop, outChan, outErr}),
            64'({qSop[qHead], qEop[qHead], qChan[qHead], qErr[qHead]}));
      check(outSop == !outInPkt, "R5", "packet framing", 64'(outSop), 64'(!outInPkt));
      check(outEmpty == (qEop[qHead] ? qEmp[qHead] : '0), "R6", "empty lanes",
            64'(outEmpty), 64'(qEop[qHead] ? qEmp[qHead] : '0));
      outInPkt = !qEop[qHead];
      qHead = (qHead + 1) % QN;
      qCount--;
    end else begin
      check({outData, outSop, outEop, outEmpty, outChan, outErr} == '0, "R7", "idle fields",
            64'({outSop, outEop, outEmpty, outChan, outErr}) | 64'(outData), 0);
    end
    // new stimulus
    len = (pktLeft == 0) ? 1 + int'($urandom % 5) : pktLeft;
    sop = (pktLeft == 0);
    eop = (len == 1);
    d  = DATA_W'($urandom);
    em = EMPTY_W'($urandom);
    ch = CHAN_W'($urandom);
    er = ERR_W'($urandom);
    accept = pushReq && !expFull;
    inPush   = pushReq;
    inData   = pushReq ? d : '0;
    inSop    = pushReq & sop;
    inEop    = pushReq & eop;
    inEmpty  = pushReq ? em : '0;
    inChan   = pushReq ? ch : '0;
    inErr    = pushReq ? er : '0;
    outReady = rdy;
    if (accept) begin
      qData[qTail] = d; qSop[qTail] = sop; qEop[qTail] = eop;
      qEmp[qTail] = em; qChan[qTail] = ch; qErr[qTail] = er;
      qTail = (qTail + 1) % QN;
      qCount++;
      pktLeft = len - 1;
    end
    for (int i = LAT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = rdy;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < LAT; i++) hist[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0 && inFull == 1'b0, "R1", "valid/full after reset",
          64'({outValid, inFull}), 0);
    check({outData, outSop, outEop, outEmpty, outChan, outErr} == '0, "R1", "fields after reset",
          64'(outData), 0);
    for (int ph = 0; ph < 5; ph++) begin
      for (int c = 0; c < 400; c++) begin
        bit r, p;
        case (ph)
          0: begin r = 1'b1; p = ($urandom % 10) < 7; end
          1: begin r = $urandom % 2 == 0; p = $urandom % 2 == 0; end
          2: begin r = (c < 20 || (c % 50) < 10) ? 1'b0 : ($urandom % 2 == 0); p = 1'b1; end
          3: begin r = 1'b1; p = ($urandom % 100) < 15; end
          default: begin r = (c % 3) == 0; p = ($urandom % 10) < 9; end
        endcase
        stepCycle(r, p);
      end
    end
    // drain with ready high and no pushes
    for (int c = 0; c < 2 * DEPTH + LAT; c++) stepCycle(1'b1, 1'b0);
    check(qCount == 0 && outValid == 1'b0, "R3", "buffer drained", 64'(outValid), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end
endmodule